// File: doc/BRIEF.md
# Standby Clock and Wake Controller

This block follows the CPU through its normal running state and its two standby states, and drives the clock enables to match. It takes single-cycle requests from the CPU to enter the light standby state ("wait") or the deep one ("stop"). It also watches the status bit that disables stop, the mask bit of the non-maskable external interrupt, and three pending-interrupt lines. From these it drives enables for the CPU clock, the peripheral clocks and the oscillator.

On every return to running, the block raises a one-cycle wake strobe with a qualifier. The qualifier tells the CPU whether to go straight into interrupt service or to resume at the instruction after the standby request. Registers are already stacked when the CPU enters standby, so a wake into service skips the stacking step.

In wait, only the CPU clock stops. Any interrupt source ends wait. In stop, every clock and the oscillator halt. Only the external sources end stop: the non-maskable line, or an IRQ edge when IRQ is configured as edge sensitive. Reset also ends stop. After a wake from stop, the block holds the CPU and peripheral clocks off for a programmable oscillator start-up count, then returns to running.

Top module: `lp_mode_ctrl`

## Requirements
- R1: Reset, asserted at any time and in any state, puts `mode` at 2'b00 (running) with `cpu_clk_en`, `per_clk_en` and `osc_en` all 1 and `wake_valid` 0.
- R2: When `wai_req` is sampled high while running, the next cycle has `mode` = 2'b01 (wait), with `cpu_clk_en` 0 and `per_clk_en` and `osc_en` 1.
- R3: In wait, a sampled high on any of `irq_line`, `xirq_req` or `int_pend` returns `mode` to 2'b00 on the next cycle. `wake_valid` is 1 for exactly that one cycle. With none of them high, wait is held.
- R4: On a wake from wait, `wake_svc` is 1 (enter service) if `irq_line` or `int_pend` was high, or if `xirq_req` was high with `x_bit` 0. It is 0 (resume after the request) if only `xirq_req` was high and `x_bit` was 1.
- R5: When `stop_req` is sampled high with `s_bit` 0 while running, the next cycle has `mode` = 2'b10 (stop), with all three enables 0.
- R6: A `stop_req` sampled with `s_bit` 1 has no effect: the block stays running with all enables 1.
- R7: In stop, `int_pend` is ignored, and so is `irq_line` while `irq_edge_mode` is 0. The block stays in stop.
- R8: In stop, a sampled high on `xirq_req`, or a rising `irq_line` while `irq_edge_mode` is 1, moves the block to `mode` 2'b11 (start-up). In start-up, only `osc_en` is 1. The block stays there for exactly STARTUP_CYCLES cycles, then returns to running with `wake_valid` high for one cycle.
- R9: After a wake from stop, `wake_svc` is 0 if the wake came only from `xirq_req` with `x_bit` 1. It is 1 if `xirq_req` woke with `x_bit` 0, or if an IRQ edge woke the block.
- R10: If `stop_req` (with `s_bit` 0) and `wai_req` are sampled in the same cycle while running, stop is entered.
- R11: `wai_req` and `stop_req` have no effect in wait, stop or start-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wai_req | input | 1 | CPU request to enter wait |
| stop_req | input | 1 | CPU request to enter stop |
| s_bit | input | 1 | Stop-disable status bit; 1 turns stop requests into no-ops |
| x_bit | input | 1 | Mask of the non-maskable external interrupt |
| xirq_req | input | 1 | Non-maskable external interrupt, active high |
| irq_line | input | 1 | Maskable external interrupt line, active high |
| irq_edge_mode | input | 1 | 1: IRQ is edge sensitive (may end stop); 0: level |
| int_pend | input | 1 | Any internal peripheral interrupt pending |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| mode | output | 2 | 00 running, 01 wait, 10 stop, 11 start-up |
| wake_valid | output | 1 | One-cycle strobe on return to running from standby |
| wake_svc | output | 1 | With the strobe: 1 enter service, 0 resume at next instruction |

## Verification
The bench builds the block with STARTUP_CYCLES set to 5. This keeps each start-up window short, so the bench can see the last start-up cycle and the first running cycle after it, and can repeat the stop sequence for every wake source within a short run. The default of 64 keeps the same counter structure with a wider count. Each cycle is compared against a behavioural model, and directed checks cover the no-op and ignore cases at the ports.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef enum logic [1:0] {
        LP_RUN  = 2'b00,
        LP_WAIT = 2'b01,
        LP_STOP = 2'b10,
        LP_WARM = 2'b11
    } lp_mode_e;

    typedef struct packed {
        lp_mode_e mode;
        logic     wake_valid;
        logic     wake_svc;
        logic     svc_pend;
    } lp_state_t;

    localparam lp_state_t LP_STATE_RST = '{
        mode:       LP_RUN,
        wake_valid: 1'b0,
        wake_svc:   1'b0,
        svc_pend:   1'b0
    };

endpackage

// File: rtl/lp_wake_detect.sv
module lp_wake_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_line,
    input  logic irq_edge_mode,
    input  logic xirq_req,
    input  logic x_bit,
    input  logic int_pend,
    output logic wait_wake,
    output logic wait_svc,
    output logic stop_wake,
    output logic stop_svc
);

    logic irq_prev_d, irq_prev_q;
    logic irq_rise, irq_edge_hit, xirq_taken;

    always_comb begin
        irq_prev_d = irq_line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_prev_q <= 1'b0;
        else        irq_prev_q <= irq_prev_d;
    end

    always_comb begin
        irq_rise     = irq_line & ~irq_prev_q;
        irq_edge_hit = irq_edge_mode & irq_rise;
        xirq_taken   = xirq_req & ~x_bit;
        // light standby: any source wakes
        wait_wake    = xirq_req | irq_line | int_pend;
        wait_svc     = irq_line | int_pend | xirq_taken;
        // deep standby: external sources only
        stop_wake    = xirq_req | irq_edge_hit;
        stop_svc     = xirq_taken | irq_edge_hit;
    end

endmodule

// File: rtl/lp_startup_timer.sv
module lp_startup_timer #(
    parameter int unsigned CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);

    localparam int unsigned EFF = (CYCLES < 1) ? 1 : CYCLES;
    localparam int unsigned CW  = $clog2(EFF + 1);
    localparam logic [CW-1:0] LAST = CW'(EFF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = active && (cnt_q == LAST);
        cnt_d = '0;
        if (active && !done) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/lp_clk_gate.sv
module lp_clk_gate
    import lp_pkg::*;
(
    input  lp_mode_e mode,
    output logic     cpu_clk_en,
    output logic     per_clk_en,
    output logic     osc_en
);

    always_comb begin
        unique case (mode)
            LP_RUN:  {cpu_clk_en, per_clk_en, osc_en} = 3'b111;
            LP_WAIT: {cpu_clk_en, per_clk_en, osc_en} = 3'b011;
            LP_STOP: {cpu_clk_en, per_clk_en, osc_en} = 3'b000;
            LP_WARM: {cpu_clk_en, per_clk_en, osc_en} = 3'b001;
            default: {cpu_clk_en, per_clk_en, osc_en} = 3'b111;
        endcase
    end

endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
    import lp_pkg::*;
#(
    parameter int unsigned STARTUP_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wai_req,
    input  logic       stop_req,
    input  logic       s_bit,
    input  logic       x_bit,
    input  logic       xirq_req,
    input  logic       irq_line,
    input  logic       irq_edge_mode,
    input  logic       int_pend,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic [1:0] mode,
    output logic       wake_valid,
    output logic       wake_svc
);

    lp_state_t st_d, st_q;
    logic wait_wake, wait_svc, stop_wake, stop_svc;
    logic warm_active, warm_done;

    lp_wake_detect u_wake (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_line      (irq_line),
        .irq_edge_mode (irq_edge_mode),
        .xirq_req      (xirq_req),
        .x_bit         (x_bit),
        .int_pend      (int_pend),
        .wait_wake     (wait_wake),
        .wait_svc      (wait_svc),
        .stop_wake     (stop_wake),
        .stop_svc      (stop_svc)
    );

    assign warm_active = (st_q.mode == LP_WARM);

    lp_startup_timer #(.CYCLES(STARTUP_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (warm_active),
        .done   (warm_done)
    );

    lp_clk_gate u_gate (
        .mode       (st_q.mode),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en),
        .osc_en     (osc_en)
    );

    always_comb begin
        st_d            = st_q;
        st_d.wake_valid = 1'b0;
        unique case (st_q.mode)
            LP_RUN: begin
                if (stop_req && !s_bit) st_d.mode = LP_STOP;
                else if (wai_req)       st_d.mode = LP_WAIT;
            end
            LP_WAIT: begin
                if (wait_wake) begin
                    st_d.mode       = LP_RUN;
                    st_d.wake_valid = 1'b1;
                    st_d.wake_svc   = wait_svc;
                end
            end
            LP_STOP: begin
                if (stop_wake) begin
                    st_d.mode     = LP_WARM;
                    st_d.svc_pend = stop_svc;
                end
            end
            LP_WARM: begin
                if (warm_done) begin
                    st_d.mode       = LP_RUN;
                    st_d.wake_valid = 1'b1;
                    st_d.wake_svc   = st_q.svc_pend;
                end
            end
            default: st_d.mode = LP_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LP_STATE_RST;
        else        st_q <= st_d;
    end

    assign mode       = st_q.mode;
    assign wake_valid = st_q.wake_valid;
    assign wake_svc   = st_q.wake_svc;

endmodule

// File: rtl/lp_mode_ctrl_chk.sv
module lp_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wai_req,
    input logic       stop_req,
    input logic       s_bit,
    input logic       x_bit,
    input logic       xirq_req,
    input logic       irq_line,
    input logic       int_pend,
    input logic [1:0] mode,
    input logic       wake_valid,
    input logic       wake_svc,
    input logic       cpu_clk_en
);

    // R6
    s_blocks_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && stop_req && s_bit && !wai_req) |=> (mode == 2'b00 && cpu_clk_en));

    // R7
    stop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && !xirq_req && !irq_line) |=> (mode == 2'b10));

    // R8
    stop_exit_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (mode == 2'b10 || mode == 2'b11));

    // R3
    wake_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (mode == 2'b00 && ($past(mode) == 2'b01 || $past(mode) == 2'b11)));

    // R3
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> !wake_valid);

    // R4
    wait_internal_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && int_pend) |=> (wake_valid && wake_svc));

    // R11
    wait_ignores_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !xirq_req && !irq_line && !int_pend && (wai_req || stop_req)) |=> (mode == 2'b01));

    // R4
    wait_xirq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && xirq_req && x_bit && !irq_line && !int_pend) |=> (wake_valid && !wake_svc));

endmodule

bind lp_mode_ctrl lp_mode_ctrl_chk i_lp_mode_ctrl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wai_req    (wai_req),
    .stop_req   (stop_req),
    .s_bit      (s_bit),
    .x_bit      (x_bit),
    .xirq_req   (xirq_req),
    .irq_line   (irq_line),
    .int_pend   (int_pend),
    .mode       (mode),
    .wake_valid (wake_valid),
    .wake_svc   (wake_svc),
    .cpu_clk_en (cpu_clk_en)
);

// File: tb/test_lp_mode_ctrl.sv
`timescale 1ns/1ps
module test_lp_mode_ctrl;

    localparam int SC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wai_req = 0, stop_req = 0, s_bit = 0, x_bit = 0;
    logic xirq_req = 0, irq_line = 0, irq_edge_mode = 0, int_pend = 0;
    logic cpu_clk_en, per_clk_en, osc_en, wake_valid, wake_svc;
    logic [1:0] mode;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    lp_mode_ctrl #(.STARTUP_CYCLES(SC)) i_lp_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .wai_req(wai_req), .stop_req(stop_req),
        .s_bit(s_bit), .x_bit(x_bit), .xirq_req(xirq_req), .irq_line(irq_line),
        .irq_edge_mode(irq_edge_mode), .int_pend(int_pend),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .mode(mode), .wake_valid(wake_valid), .wake_svc(wake_svc)
    );

    // behavioural reference: 0 run, 1 wait, 2 stop, 3 start-up
    int m_mode = 0, m_cnt = 0;
    bit m_prev = 0, m_wv = 0, m_svc = 0, m_pend = 0;

    function automatic logic [2:0] en_of(input int md);
        if (md == 0) return 3'b111;
        if (md == 1) return 3'b011;
        if (md == 2) return 3'b000;
        return 3'b001;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_prev = 0; m_wv = 0; m_svc = 0; m_pend = 0;
        end else begin
            bit edge_hit;
            edge_hit = irq_edge_mode && irq_line && !m_prev;
            m_wv = 0;
            if (m_mode == 0) begin
                if (stop_req && !s_bit) m_mode = 2;
                else if (wai_req) m_mode = 1;
            end else if (m_mode == 1) begin
                if (xirq_req || irq_line || int_pend) begin
                    m_mode = 0; m_wv = 1;
                    m_svc = irq_line || int_pend || (xirq_req && !x_bit);
                end
            end else if (m_mode == 2) begin
                if (xirq_req || edge_hit) begin
                    m_mode = 3; m_cnt = 0;
                    m_pend = (xirq_req && !x_bit) || edge_hit;
                end
            end else begin
                if (m_cnt == SC - 1) begin
                    m_mode = 0; m_wv = 1; m_svc = m_pend;
                end else m_cnt++;
            end
            m_prev = irq_line;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            string t;
            t = (m_mode == 0) ? "R1 run" : (m_mode == 1) ? "R2 wait" :
                (m_mode == 2) ? "R5 stop" : "R8 startup";
            chk({t, " mode/enables"}, {mode, cpu_clk_en, per_clk_en, osc_en},
                {m_mode[1:0], en_of(m_mode)});
            chk("R3 wake_valid", wake_valid, m_wv);
            if (m_wv) chk("R4 R9 wake_svc", wake_svc, m_svc);
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic expect_st(input string tag, input int md);
        chk(tag, {mode, cpu_clk_en, per_clk_en, osc_en}, {md[1:0], en_of(md)});
    endtask

    task automatic enter_stop();
        stop_req = 1; tick(); stop_req = 0;
        expect_st("R5 stop entry", 2);
    endtask

    task automatic finish_warm(input string tag, input bit svc);
        expect_st({tag, " startup"}, 3);
        repeat (SC - 1) tick();
        expect_st({tag, " last startup cycle"}, 3);
        tick();
        expect_st({tag, " back to run"}, 0);
        chk({tag, " wake strobe"}, wake_valid, 1);
        chk({tag, " wake_svc"}, wake_svc, svc);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        expect_st("R1 in reset", 0);
        rst_n = 1;
        tick();
        expect_st("R1 after reset", 0);
        chk("R1 no strobe", wake_valid, 0);

        // wait via internal interrupt
        wai_req = 1; tick(); wai_req = 0;
        expect_st("R2 wait entry", 1);
        tick(); tick();
        expect_st("R3 wait held", 1);
        wai_req = 1; stop_req = 1; tick(); wai_req = 0; stop_req = 0;
        expect_st("R11 requests in wait", 1);
        int_pend = 1; tick(); int_pend = 0;
        expect_st("R3 wake from wait", 0);
        chk("R3 strobe", wake_valid, 1);
        chk("R4 internal svc", wake_svc, 1);
        tick();
        chk("R3 strobe one cycle", wake_valid, 0);

        // wait, masked XIRQ
        wai_req = 1; tick(); wai_req = 0;
        x_bit = 1; xirq_req = 1; tick(); xirq_req = 0;
        chk("R4 masked xirq resume", {wake_valid, wake_svc}, 2'b10);
        // wait, IRQ
        wai_req = 1; tick(); wai_req = 0;
        irq_line = 1; tick(); irq_line = 0;
        chk("R4 irq svc", {wake_valid, wake_svc}, 2'b11);
        tick();

        // S set: stop is a no-op
        s_bit = 1; stop_req = 1; tick(); stop_req = 0;
        expect_st("R6 stop ignored", 0);
        tick();
        expect_st("R6 still run", 0);
        s_bit = 0;

        // stop wins over wait
        stop_req = 1; wai_req = 1; tick(); stop_req = 0; wai_req = 0;
        expect_st("R10 stop priority", 2);
        int_pend = 1; irq_line = 1; tick(); tick();
        expect_st("R7 stop ignores level irq and internal", 2);
        wai_req = 1; stop_req = 1; tick(); wai_req = 0; stop_req = 0;
        expect_st("R11 requests in stop", 2);
        int_pend = 0; irq_line = 0; tick();
        xirq_req = 1; x_bit = 1; tick(); xirq_req = 0;
        wai_req = 1; tick(); wai_req = 0;
        expect_st("R11 request in startup", 3);
        repeat (SC - 2) tick();
        expect_st("R8 last startup cycle", 3);
        tick();
        expect_st("R8 run after startup", 0);
        chk("R9 masked xirq resume", {wake_valid, wake_svc}, 2'b10);
        tick();

        // stop, XIRQ with X clear
        x_bit = 0; enter_stop();
        xirq_req = 1; tick(); xirq_req = 0;
        finish_warm("R9 xirq", 1);
        tick();

        // stop, IRQ edge
        irq_edge_mode = 1; enter_stop();
        irq_line = 1; tick(); irq_line = 0;
        finish_warm("R8 irq edge", 1);
        tick();

        // reset during stop
        enter_stop();
        rst_n = 0; #1;
        expect_st("R1 reset from stop", 0);
        tick();
        rst_n = 1; tick();
        expect_st("R1 run after reset release", 0);
        repeat (3) tick();

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule